// File: doc/BRIEF.md
# Tweakable Cipher Subkey Generator

This block produces the round subkeys of a tweakable block cipher with 64-bit words and a 4-word (256-bit) block. A load strobe captures a key of `NW` words and a 128-bit tweak. In that same cycle the block works out one extra key word: a fixed constant XORed with every key word. It also works out a third tweak word, the XOR of the two tweak halves. The subkeys are never stored. On each request the block assembles the next subkey from the extended key and tweak, using rotating indices.

Subkeys come out in order, with counter values `s = 0 .. NR/4`. For the default `NR = 72` that is 19 subkeys. Words 1 and 2 of each subkey get a tweak word added, and word 3 gets the counter `s` added. All additions are modulo 2^64. A completion flag marks the last subkey. Further requests are ignored until the next load.

Top module: `tweak_subkey_gen`

## Requirements
- R1: After reset `valid_o`, `done_o`, `sidx_o` and `subkey_o` are all zero.
- R2: A load captures `key_i` (word j at bits `[64j+63:64j]`) and `tweak_i` (t0 at `[63:0]`, t1 at `[127:64]`), and restarts the sequence so that the next accepted request yields subkey s = 0.
- R3: The extended key word k4 equals 0x1BD11BDAA9FC1A22 XOR k0 XOR k1 XOR k2 XOR k3, and is used wherever an index selects position 4.
- R4: The extended tweak word t2 equals t0 XOR t1.
- R5: Subkey word 0 (bits `[63:0]` of `subkey_o`) of subkey s equals k[s mod 5].
- R6: Subkey word 1 equals k[(s+1) mod 5] + t[s mod 3], modulo 2^64.
- R7: Subkey word 2 equals k[(s+2) mod 5] + t[(s+1) mod 3], modulo 2^64.
- R8: Subkey word 3 equals k[(s+3) mod 5] + s, modulo 2^64.
- R9: A request accepted at a clock edge makes `valid_o` high for exactly the following cycle, with `sidx_o` = s. Outside such cycles `subkey_o` and `sidx_o` hold their values.
- R10: Exactly NR/4+1 subkeys (19 by default) are issued per load, and `done_o` rises in the cycle that presents subkey s = NR/4.
- R11: Requests after the final subkey are ignored: `valid_o` stays low, `subkey_o` and `sidx_o` are unchanged, and `done_o` stays high until a load.
- R12: A load in the same cycle as a request takes priority: no subkey is issued, `done_o` clears, and the sequence restarts at s = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture key and tweak, restart sequence |
| key_i | input | NW*64 | Cipher key, word j at bits 64j upward |
| tweak_i | input | 128 | Tweak, t0 in low half, t1 in high half |
| req_i | input | 1 | Request next subkey |
| valid_o | output | 1 | Subkey presented this cycle |
| done_o | output | 1 | Final subkey has been issued |
| sidx_o | output | SIDX_W | Counter s of the presented subkey |
| subkey_o | output | NW*64 | Subkey, word i at bits 64i upward |

## Verification
The wrapping key index (period 5) and the wrapping tweak index (period 3) line up only every 15 subkeys. A short sequence would therefore never check every pairing against the extended words. The stimulus walks the full 19-subkey run for several key and tweak patterns, including all-ones values that force carries through every adder. A reference model built from plain modulo arithmetic computes each expected word.

The hardest corners to reach are the cycles at the very end of a run and a load that collides with a request. The bench drives extra requests after `done_o` rises. It also asserts load and request together in the middle of a run and at the end of one. In each case it watches that no subkey is emitted and that the next run starts again from s = 0.

// File: rtl/skg_pkg.sv
package skg_pkg;
  localparam int WORD_W = 64;
  localparam logic [WORD_W-1:0] PARITY_C = 64'h1BD11BDAA9FC1A22;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/skg_ext.sv
module skg_ext
  import skg_pkg::*;
#(
  parameter int NW = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [NW-1:0][WORD_W-1:0] key_i,
  input  logic [1:0][WORD_W-1:0]  tweak_i,
  output logic [NW:0][WORD_W-1:0] ext_key_o,
  output logic [2:0][WORD_W-1:0]  ext_tw_o
);
  word_t parity;

  always_comb begin
    parity = PARITY_C;
    for (int j = 0; j < NW; j++) parity = parity ^ key_i[j];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_key_o <= '0;
      ext_tw_o  <= '0;
    end else if (load_i) begin
      for (int j = 0; j < NW; j++) ext_key_o[j] <= key_i[j];
      ext_key_o[NW] <= parity;
      ext_tw_o[0]   <= tweak_i[0];
      ext_tw_o[1]   <= tweak_i[1];
      ext_tw_o[2]   <= tweak_i[0] ^ tweak_i[1];
    end
  end

  // R3
  parity_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ext_key_o[NW] == (PARITY_C ^ $past(key_i[0]) ^ $past(key_i[1])
                                 ^ $past(key_i[2]) ^ $past(key_i[NW-1])));
  // R4
  tweak_xor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ext_tw_o[2] == ($past(tweak_i[0]) ^ $past(tweak_i[1])));
endmodule

// File: rtl/skg_sched.sv
module skg_sched #(
  parameter int NW = 4,
  parameter int NR = 72,
  parameter int SW = $clog2(NR/4 + 1),
  parameter int BW = $clog2(NW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          adv_i,
  output logic [SW-1:0] s_o,
  output logic [BW-1:0] base_o,
  output logic [1:0]    tsel_o,
  output logic          exh_o
);
  localparam int LAST = NR / 4;
  localparam logic [SW-1:0] LAST_S = SW'(LAST);
  localparam logic [BW-1:0] BASE_MAX = BW'(NW);

  // wrapping counters replace the modulo operations
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_o    <= '0;
      base_o <= '0;
      tsel_o <= '0;
      exh_o  <= 1'b0;
    end else if (load_i) begin
      s_o    <= '0;
      base_o <= '0;
      tsel_o <= '0;
      exh_o  <= 1'b0;
    end else if (adv_i && !exh_o) begin
      if (s_o == LAST_S) begin
        exh_o <= 1'b1;
      end else begin
        s_o    <= s_o + 1'b1;
        base_o <= (base_o == BASE_MAX) ? '0 : base_o + 1'b1;
        tsel_o <= (tsel_o == 2'd2) ? 2'd0 : tsel_o + 2'd1;
      end
    end
  end

  // R10
  s_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && !exh_o && s_o != LAST_S) |=> s_o == $past(s_o) + 1'b1);
  // R10
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_o <= BASE_MAX) && (tsel_o <= 2'd2) && (s_o <= LAST_S));
  // R11
  exh_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exh_o && !load_i) |=> exh_o);
endmodule

// File: rtl/skg_assemble.sv
module skg_assemble
  import skg_pkg::*;
#(
  parameter int NW = 4,
  parameter int SW = 5,
  parameter int BW = $clog2(NW + 1)
) (
  input  logic [NW:0][WORD_W-1:0]   ext_key_i,
  input  logic [2:0][WORD_W-1:0]    ext_tw_i,
  input  logic [SW-1:0]             s_i,
  input  logic [BW-1:0]             base_i,
  input  logic [1:0]                tsel_i,
  output logic [NW-1:0][WORD_W-1:0] subkey_o
);
  logic [1:0] tsel_n;
  assign tsel_n = (tsel_i == 2'd2) ? 2'd0 : tsel_i + 2'd1;

  for (genvar i = 0; i < NW; i++) begin : g_word
    logic [BW:0]   raw;
    logic [BW-1:0] idx;
    word_t         kw;
    assign raw = {1'b0, base_i} + (BW+1)'(i);
    assign idx = (raw > (BW+1)'(NW)) ? BW'(raw - (BW+1)'(NW + 1)) : raw[BW-1:0];
    assign kw  = ext_key_i[idx];
    if (i == NW - 3) begin : g_tw_a
      assign subkey_o[i] = kw + ext_tw_i[tsel_i];
    end else if (i == NW - 2) begin : g_tw_b
      assign subkey_o[i] = kw + ext_tw_i[tsel_n];
    end else if (i == NW - 1) begin : g_cnt
      assign subkey_o[i] = kw + WORD_W'(s_i);
    end else begin : g_plain
      assign subkey_o[i] = kw;
    end
  end
endmodule

// File: rtl/tweak_subkey_gen.sv
module tweak_subkey_gen
  import skg_pkg::*;
#(
  parameter int NW     = 4,
  parameter int NR     = 72,
  parameter int SIDX_W = $clog2(NR/4 + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [NW*64-1:0]     key_i,
  input  logic [127:0]         tweak_i,
  input  logic                 req_i,
  output logic                 valid_o,
  output logic                 done_o,
  output logic [SIDX_W-1:0]    sidx_o,
  output logic [NW*64-1:0]     subkey_o
);
  localparam int BW = $clog2(NW + 1);
  localparam logic [SIDX_W-1:0] LAST_S = SIDX_W'(NR / 4);

  logic [NW-1:0][WORD_W-1:0] key_w;
  logic [1:0][WORD_W-1:0]    tw_w;
  logic [NW:0][WORD_W-1:0]   ext_key;
  logic [2:0][WORD_W-1:0]    ext_tw;
  logic [NW-1:0][WORD_W-1:0] sk_comb;
  logic [SIDX_W-1:0]         s_cur;
  logic [BW-1:0]             base;
  logic [1:0]                tsel;
  logic                      exh;
  logic                      fire;

  assign key_w = key_i;
  assign tw_w  = tweak_i;
  assign fire  = req_i && !load_i && !exh;

  skg_ext #(.NW(NW)) u_ext (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .key_i     (key_w),
    .tweak_i   (tw_w),
    .ext_key_o (ext_key),
    .ext_tw_o  (ext_tw)
  );

  skg_sched #(.NW(NW), .NR(NR), .SW(SIDX_W), .BW(BW)) u_sched (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .adv_i  (req_i),
    .s_o    (s_cur),
    .base_o (base),
    .tsel_o (tsel),
    .exh_o  (exh)
  );

  skg_assemble #(.NW(NW), .SW(SIDX_W), .BW(BW)) u_asm (
    .ext_key_i (ext_key),
    .ext_tw_i  (ext_tw),
    .s_i       (s_cur),
    .base_i    (base),
    .tsel_i    (tsel),
    .subkey_o  (sk_comb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      sidx_o   <= '0;
      subkey_o <= '0;
    end else begin
      valid_o <= fire;
      if (fire) begin
        sidx_o   <= s_cur;
        subkey_o <= sk_comb;
      end
    end
  end

  assign done_o = exh;

  // R10
  last_sets_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && sidx_o == LAST_S) |-> done_o);
  // R11
  ignore_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && req_i) |=> (!valid_o && $stable(subkey_o) && $stable(sidx_o)));
  // R12
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (!valid_o && !done_o));
  // R9
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(subkey_o));
endmodule

// File: tb/tweak_subkey_gen_test.sv
module tweak_subkey_gen_test;
  localparam int NW = 4;
  localparam int NR = 72;
  localparam int LAST = NR / 4;
  localparam int SW = $clog2(LAST + 1);
  localparam logic [63:0] PC = 64'h1BD11BDAA9FC1A22;

  // {key (256), tweak (128)}
  localparam logic [383:0] STIM [3] = '{
    {256'h0, 128'h0},
    {{256{1'b1}}, {128{1'b1}}},
    {64'hF0E1D2C3B4A59687, 64'h0123456789ABCDEF, 64'hDEADBEEFCAFEF00D, 64'h8000000000000001,
     64'hFFFFFFFFFFFFFFF0, 64'h13579BDF2468ACE0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic load_i = 1'b0;
  logic [255:0] key_i = '0;
  logic [127:0] tweak_i = '0;
  logic req_i = 1'b0;
  logic valid_o, done_o;
  logic [SW-1:0] sidx_o;
  logic [255:0] subkey_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tweak_subkey_gen #(.NW(NW), .NR(NR)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load_i), .key_i(key_i),
    .tweak_i(tweak_i), .req_i(req_i), .valid_o(valid_o), .done_o(done_o),
    .sidx_o(sidx_o), .subkey_o(subkey_o)
  );

  function automatic logic [255:0] model(input logic [255:0] k, input logic [127:0] t, input int s);
    logic [63:0] kx [5];
    logic [63:0] tx [3];
    logic [255:0] r;
    kx[4] = PC;
    for (int i = 0; i < 4; i++) begin
      kx[i] = k[64*i +: 64];
      kx[4] = kx[4] ^ kx[i];
    end
    tx[0] = t[63:0];
    tx[1] = t[127:64];
    tx[2] = tx[0] ^ tx[1];
    for (int i = 0; i < 4; i++) r[64*i +: 64] = kx[(s + i) % 5];
    r[64 +: 64]  = r[64 +: 64]  + tx[s % 3];
    r[128 +: 64] = r[128 +: 64] + tx[(s + 1) % 3];
    r[192 +: 64] = r[192 +: 64] + 64'(s);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [255:0] k, input logic [127:0] t, input logic with_req);
    key_i = k; tweak_i = t; load_i = 1'b1; req_i = with_req;
    @(posedge clk); #1;
    load_i = 1'b0; req_i = 1'b0;
  endtask

  task automatic do_req();
    req_i = 1'b1;
    @(posedge clk); #1;
    req_i = 1'b0;
  endtask

  task automatic check_subkey(input logic [255:0] k, input logic [127:0] t, input int s);
    logic [255:0] e;
    e = model(k, t, s);
    chk("R9 valid", 256'(valid_o), 256'(1));
    chk("R9 sidx", 256'(sidx_o), 256'(s));
    chk((s % 5 == 4) ? "R3 word0" : "R5 word0", 256'(subkey_o[63:0]), 256'(e[63:0]));
    chk("R6 word1", 256'(subkey_o[127:64]), 256'(e[127:64]));
    chk((s % 3 == 1) ? "R4 word2" : "R7 word2", 256'(subkey_o[191:128]), 256'(e[191:128]));
    chk("R8 word3", 256'(subkey_o[255:192]), 256'(e[255:192]));
    chk("R10 done", 256'(done_o), 256'(s == LAST));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [255:0] hold;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 valid", 256'(valid_o), 256'(0));
    chk("R1 done", 256'(done_o), 256'(0));
    chk("R1 sidx", 256'(sidx_o), 256'(0));
    chk("R1 subkey", subkey_o, 256'(0));
    rst_ni = 1'b1;
    @(posedge clk); #1;

    // table walk: full run per vector (R2, R3..R8, R10, R11)
    for (int v = 0; v < 3; v++) begin
      logic [255:0] k;
      logic [127:0] t;
      k = STIM[v][383:128];
      t = STIM[v][127:0];
      do_load(k, t, 1'b0);
      chk("R12 done cleared by load", 256'(done_o), 256'(0));
      for (int s = 0; s <= LAST; s++) begin
        do_req();
        check_subkey(k, t, s);
        hold = subkey_o;
        @(posedge clk); #1;
        chk("R9 single pulse", 256'(valid_o), 256'(0));
        chk("R9 held", subkey_o, hold);
      end
      for (int x = 0; x < 2; x++) begin
        do_req();
        chk("R11 no valid", 256'(valid_o), 256'(0));
        chk("R11 subkey held", subkey_o, hold);
        chk("R11 sidx held", 256'(sidx_o), 256'(LAST));
        chk("R11 done held", 256'(done_o), 256'(1));
      end
    end

    // hand values: zero key/tweak, s=1 word3 = parity constant + 1
    do_load(256'h0, 128'h0, 1'b0);
    do_req();
    chk("R2 restart sidx", 256'(sidx_o), 256'(0));
    do_req();
    chk("R8 hand word3", 256'(subkey_o[255:192]), 256'(64'h1BD11BDAA9FC1A23));
    for (int s = 2; s < 5; s++) do_req();
    chk("R3 hand parity", 256'(subkey_o[63:0]), 256'(PC));

    // load colliding with request mid-run
    do_load(STIM[2][383:128], STIM[2][127:0], 1'b1);
    chk("R12 no valid on load+req", 256'(valid_o), 256'(0));
    chk("R12 done low", 256'(done_o), 256'(0));
    do_req();
    check_subkey(STIM[2][383:128], STIM[2][127:0], 0);

    // load colliding with request after done
    for (int s = 1; s <= LAST; s++) do_req();
    chk("R10 done at end", 256'(done_o), 256'(1));
    do_load(STIM[1][383:128], STIM[1][127:0], 1'b1);
    chk("R12 done cleared", 256'(done_o), 256'(0));
    chk("R12 no valid", 256'(valid_o), 256'(0));
    do_req();
    check_subkey(STIM[1][383:128], STIM[1][127:0], 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule